// File: doc/BRIEF.md
# Block-Cipher Register and Handshake Front End

This block is the software-facing shell around a 128-bit block-cipher core. A 32-bit register bus loads the key, the initial vector and the mode, and then a payload byte count that starts an operation. Input blocks arrive as four 32-bit words in a data window. The block wraps each one for the selected chaining mode, hands it to the external core with a one-cycle start pulse, and captures the result when the core signals done. The result is returned through the same window. Two status flags, one for input wanted and one for output available, take turns. Each flag can raise the interrupt line or, independently, a DMA request.

Chaining is done here, not in the core. In electronic-codebook mode the block passes data straight through. In chained mode it XORs with the running vector on the correct side of the core for the direction. In counter mode the core encrypts the vector and the block XORs the result into the payload. The running vector moves forward after every block and can be read back once the operation ends. The remaining byte count drops by one block, or by what is left, each time an output block has been fully read.

Top module: `cipher_regfront`

## Requirements
- R1: After reset, every readable register returns 0, `irq_o` and both DMA requests are low, and the revision word (offset 0x80) carries the major version in bits [10:8] and the minor version in bits [5:0].
- R2: Writing a nonzero value to the payload length register (0x54) while idle starts an operation and sets status bit 1 (input wanted). `irq_o` is the OR of status bits 1 and 2, each ANDed with the same bit of the enable register (0x90), so an enable value of 0 holds `irq_o` low.
- R3: The data window at 0x60 + 4*i maps word i to block bits [32i+31:32i]. The core receives exactly one `core_start_o` pulse, one cycle long, and only after all four distinct word indices have been written while input is wanted.
- R4: Control register (0x50) fields: bit 2 set means encrypt; bit 5 selects chained mode; bit 6 selects counter mode; bit 7 selects authenticated counter mode. Counter or authenticated mode overrides chained mode; with none of the three set, the mode is codebook. Counter modes always drive `core_encrypt_o` high. The returned block is F(d) for codebook. For chained encrypt it is F(d xor V); for chained decrypt it is F(d) xor V; for counter it is d xor F(V).
- R5: A `core_done_i` while the core is busy captures the output block and sets status bit 2 (output available).
- R6: Once all four window words have been read while output is available, the remaining count (read at 0x54) drops by min(16, remaining). If the count is still nonzero, status bit 1 is set again; otherwise the block goes idle.
- R7: Writing the status register (0x8C) replaces it with its old value ANDed with the written data, so writing a bit as 1 leaves it unchanged and writing it as 0 clears it.
- R8: After each block the vector becomes the ciphertext in chained encrypt, the input ciphertext in chained decrypt, and itself plus one modulo 2^128 in counter modes. Its words stay readable at 0x40..0x4C after completion.
- R9: In the DMA register (0x84), bit 0 is start, bit 5 enables input DMA and bit 6 enables output DMA. `dma_in_req_o` is high only while input is wanted with bits 0 and 5 set, and `dma_out_req_o` is high only while output is available with bits 0 and 6 set.
- R10: Control bits [4:3] hold (key bytes / 8) - 1 and drive `core_key_size_o`. Key word i at 0x00 + 4*i drives `core_key_o` bits [32i+31:32i]. Key words read as 0, and writes to 0x20..0x3C change nothing.
- R11: While an operation is in progress, writes to the key, vector, control and length registers are ignored. Window reads have no effect unless output is available.
- R12: The second length register (0x58) and the associated-data length register (0x5C) return what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effect on data window) |
| reg_addr_i | input | 8 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address |
| irq_o | output | 1 | Interrupt request |
| dma_in_req_o | output | 1 | Input DMA request |
| dma_out_req_o | output | 1 | Output DMA request |
| core_start_o | output | 1 | One-cycle start pulse to the cipher core |
| core_din_o | output | 128 | Block presented to the core |
| core_key_o | output | 256 | Key words to the core |
| core_key_size_o | output | 2 | Key size code |
| core_encrypt_o | output | 1 | Core direction, high for encrypt |
| core_done_i | input | 1 | Core result valid pulse |
| core_dout_i | input | 128 | Core result |

## Verification
The hardest situations to reach are the ones where the front end must refuse something in the middle of an operation. Examples are a configuration write after the length has already started a block, a partial fill of three words, and a window read while input is still wanted. Directed sequences stop inside the input phase and issue exactly these accesses. They then confirm through the remaining count, the status flags and the final output and vector readback that nothing moved. Counter wrap from an all-ones vector and short final blocks are forced directly. Random operations cover every mode, direction, key size and payload length up to five blocks.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int BLK_WORDS = 4;
  localparam int WORD_W    = 32;
  localparam int BLK_W     = BLK_WORDS * WORD_W;
  localparam int BLK_BYTES = BLK_W / 8;

  localparam logic [7:0] A_IV    = 8'h40;
  localparam logic [7:0] A_CTRL  = 8'h50;
  localparam logic [7:0] A_LEN0  = 8'h54;
  localparam logic [7:0] A_LEN1  = 8'h58;
  localparam logic [7:0] A_ALEN  = 8'h5C;
  localparam logic [7:0] A_DATA  = 8'h60;
  localparam logic [7:0] A_REV   = 8'h80;
  localparam logic [7:0] A_DMA   = 8'h84;
  localparam logic [7:0] A_ISTAT = 8'h8C;
  localparam logic [7:0] A_IEN   = 8'h90;

  localparam int C_DIR   = 2;
  localparam int C_CHAIN = 5;
  localparam int C_CTR   = 6;
  localparam int C_AUTH  = 7;
  localparam int D_START = 0;
  localparam int D_IN    = 5;
  localparam int D_OUT   = 6;
  localparam int I_IN    = 1;
  localparam int I_OUT   = 2;

  typedef enum logic [1:0] {CM_ECB, CM_CBC, CM_CTR} chain_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_FILL, SQ_BUSY, SQ_DRAIN} seq_e;

  // counter family wins over chaining
  function automatic chain_e pick_chain(logic chain, logic ctr, logic auth);
    if (ctr || auth) return CM_CTR;
    if (chain)       return CM_CBC;
    return CM_ECB;
  endfunction
endpackage

// File: rtl/cf_chain_unit.sv
module cf_chain_unit
  import cf_pkg::*;
#(
  parameter int BW = 128
) (
  input  chain_e        mode_i,
  input  logic          encrypt_i,
  input  logic [BW-1:0] iv_i,
  input  logic [BW-1:0] blk_i,
  input  logic [BW-1:0] core_res_i,
  output logic [BW-1:0] core_din_o,
  output logic [BW-1:0] blk_o,
  output logic [BW-1:0] iv_next_o
);
  always_comb begin
    core_din_o = blk_i;
    blk_o      = core_res_i;
    iv_next_o  = iv_i;
    unique case (mode_i)
      CM_CBC: begin
        if (encrypt_i) begin
          core_din_o = blk_i ^ iv_i;
          iv_next_o  = core_res_i;
        end else begin
          blk_o      = core_res_i ^ iv_i;
          iv_next_o  = blk_i;
        end
      end
      CM_CTR: begin
        core_din_o = iv_i;
        blk_o      = blk_i ^ core_res_i;
        iv_next_o  = iv_i + BW'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cf_block_seq.sv
module cf_block_seq
  import cf_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int LW    = 32,
  localparam int IDXW = $clog2(WORDS),
  localparam int BW   = WORDS * DW,
  localparam int STEP = BW / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic [LW-1:0]   len_i,
  input  logic            wr_word_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            rd_word_i,
  input  logic [IDXW-1:0] rd_idx_i,
  input  logic            core_done_i,
  input  logic [BW-1:0]   blk_res_i,
  output seq_e            state_o,
  output logic [LW-1:0]   rem_o,
  output logic [BW-1:0]   blk_in_o,
  output logic [BW-1:0]   blk_out_o,
  output logic            core_start_o,
  output logic            in_evt_o,
  output logic            out_evt_o
);
  seq_e             state_q;
  logic [LW-1:0]    rem_q, step, rem_after;
  logic [WORDS-1:0] wmask_q, rmask_q, wmask_nx, rmask_nx;
  logic             wr_ok, rd_ok, fill_done, drain_done, start_q;
  logic [BW-1:0]    out_q;

  assign wr_ok      = wr_word_i && state_q == SQ_FILL;
  assign rd_ok      = rd_word_i && state_q == SQ_DRAIN;
  assign wmask_nx   = wmask_q | (wr_ok ? (WORDS'(1) << wr_idx_i) : '0);
  assign rmask_nx   = rmask_q | (rd_ok ? (WORDS'(1) << rd_idx_i) : '0);
  assign fill_done  = wr_ok && (&wmask_nx);
  assign drain_done = rd_ok && (&rmask_nx);
  assign step       = (rem_q < LW'(STEP)) ? rem_q : LW'(STEP);
  assign rem_after  = rem_q - step;

  assign in_evt_o  = (state_q == SQ_IDLE && go_i && len_i != '0)
                   || (drain_done && rem_after != '0);
  assign out_evt_o = state_q == SQ_BUSY && core_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      rem_q   <= '0;
      wmask_q <= '0;
      rmask_q <= '0;
      start_q <= 1'b0;
      out_q   <= '0;
    end else begin
      start_q <= fill_done;
      unique case (state_q)
        SQ_IDLE: if (go_i && len_i != '0) begin
          rem_q   <= len_i;
          wmask_q <= '0;
          state_q <= SQ_FILL;
        end
        SQ_FILL: begin
          wmask_q <= wmask_nx;
          if (fill_done) state_q <= SQ_BUSY;
        end
        SQ_BUSY: if (core_done_i) begin
          out_q   <= blk_res_i;
          rmask_q <= '0;
          state_q <= SQ_DRAIN;
        end
        SQ_DRAIN: begin
          rmask_q <= rmask_nx;
          if (drain_done) begin
            rem_q   <= rem_after;
            wmask_q <= '0;
            state_q <= (rem_after != '0) ? SQ_FILL : SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          word_q <= '0;
      else if (wr_ok && wr_idx_i == IDXW'(g)) word_q <= wdata_i;
    end
    assign blk_in_o[g*DW +: DW] = word_q;
  end

  assign state_o      = state_q;
  assign rem_o        = rem_q;
  assign blk_out_o    = out_q;
  assign core_start_o = start_q;

  assert_start_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);
  assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> (state_q == SQ_BUSY && rem_q != '0));
  assert_rem_nonincr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SQ_IDLE) |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/cipher_regfront.sv
module cipher_regfront
  import cf_pkg::*;
#(
  parameter int KEY_WORDS = 8,
  parameter int LEN_W     = 32,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 5,
  localparam int KEY_W    = KEY_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              dma_in_req_o,
  output logic              dma_out_req_o,
  output logic              core_start_o,
  output logic [BLK_W-1:0]  core_din_o,
  output logic [KEY_W-1:0]  core_key_o,
  output logic [1:0]        core_key_size_o,
  output logic              core_encrypt_o,
  input  logic              core_done_i,
  input  logic [BLK_W-1:0]  core_dout_i
);
  seq_e             seq_state;
  logic [LEN_W-1:0] rem;
  logic [BLK_W-1:0] blk_in, blk_out, chain_out, iv_next, iv_q;
  logic             in_evt, out_evt, idle, cfg_wr, go;
  logic             hit_key, hit_iv, hit_data;
  logic [31:0]      key_q [KEY_WORDS];
  logic [7:2]       ctrl_q;
  logic [LEN_W-1:0] len1_q, alen_q;
  logic [2:0]       dma_q;
  logic [2:1]       stat_q, ien_q, stat_nx;
  chain_e           mode;
  logic             unused_addr;

  assign unused_addr = ^reg_addr_i[1:0];
  assign idle     = seq_state == SQ_IDLE;
  assign cfg_wr   = reg_wr_i && idle;
  assign hit_key  = reg_addr_i[7:6] == 2'b00;
  assign hit_iv   = reg_addr_i[7:4] == A_IV[7:4];
  assign hit_data = reg_addr_i[7:4] == A_DATA[7:4];
  assign go       = cfg_wr && reg_addr_i == A_LEN0;
  assign mode     = pick_chain(ctrl_q[C_CHAIN], ctrl_q[C_CTR], ctrl_q[C_AUTH]);

  cf_block_seq #(.WORDS(BLK_WORDS), .DW(WORD_W), .LW(LEN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .len_i       (reg_wdata_i[LEN_W-1:0]),
    .wr_word_i   (reg_wr_i && hit_data),
    .wr_idx_i    (reg_addr_i[3:2]),
    .wdata_i     (reg_wdata_i),
    .rd_word_i   (reg_rd_i && hit_data),
    .rd_idx_i    (reg_addr_i[3:2]),
    .core_done_i (core_done_i),
    .blk_res_i   (chain_out),
    .state_o     (seq_state),
    .rem_o       (rem),
    .blk_in_o    (blk_in),
    .blk_out_o   (blk_out),
    .core_start_o(core_start_o),
    .in_evt_o    (in_evt),
    .out_evt_o   (out_evt)
  );

  cf_chain_unit #(.BW(BLK_W)) u_chain (
    .mode_i    (mode),
    .encrypt_i (ctrl_q[C_DIR]),
    .iv_i      (iv_q),
    .blk_i     (blk_in),
    .core_res_i(core_dout_i),
    .core_din_o(core_din_o),
    .blk_o     (chain_out),
    .iv_next_o (iv_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < KEY_WORDS; i++) key_q[i] <= '0;
    end else if (cfg_wr && hit_key) begin
      for (int i = 0; i < KEY_WORDS; i++)
        if (reg_addr_i[5:2] == 4'(i)) key_q[i] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_q <= '0;
    end else if (out_evt) begin
      iv_q <= iv_next;
    end else if (cfg_wr && hit_iv) begin
      for (int i = 0; i < BLK_WORDS; i++)
        if (reg_addr_i[3:2] == 2'(i)) iv_q[i*WORD_W +: WORD_W] <= reg_wdata_i;
    end
  end

  always_comb begin
    stat_nx = stat_q;
    if (reg_wr_i && reg_addr_i == A_ISTAT) stat_nx = stat_q & reg_wdata_i[2:1];
    if (in_evt)  stat_nx[I_IN]  = 1'b1;
    if (out_evt) stat_nx[I_OUT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      len1_q <= '0;
      alen_q <= '0;
      dma_q  <= '0;
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_nx;
      if (cfg_wr && reg_addr_i == A_CTRL) ctrl_q <= reg_wdata_i[7:2];
      if (cfg_wr && reg_addr_i == A_LEN1) len1_q <= reg_wdata_i[LEN_W-1:0];
      if (cfg_wr && reg_addr_i == A_ALEN) alen_q <= reg_wdata_i[LEN_W-1:0];
      if (reg_wr_i && reg_addr_i == A_DMA)
        dma_q <= {reg_wdata_i[D_OUT], reg_wdata_i[D_IN], reg_wdata_i[D_START]};
      if (reg_wr_i && reg_addr_i == A_IEN) ien_q <= reg_wdata_i[2:1];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (hit_iv)        reg_rdata_o = iv_q[reg_addr_i[3:2]*WORD_W +: WORD_W];
    else if (hit_data) reg_rdata_o = blk_out[reg_addr_i[3:2]*WORD_W +: WORD_W];
    else begin
      unique case (reg_addr_i)
        A_CTRL:  reg_rdata_o = {24'b0, ctrl_q, 2'b0};
        A_LEN0:  reg_rdata_o = 32'(rem);
        A_LEN1:  reg_rdata_o = 32'(len1_q);
        A_ALEN:  reg_rdata_o = 32'(alen_q);
        A_REV:   reg_rdata_o = {21'b0, 3'(REV_MAJOR), 2'b0, 6'(REV_MINOR)};
        A_DMA:   reg_rdata_o = {25'b0, dma_q[2], dma_q[1], 4'b0, dma_q[0]};
        A_ISTAT: reg_rdata_o = {29'b0, stat_q, 1'b0};
        A_IEN:   reg_rdata_o = {29'b0, ien_q, 1'b0};
        default: reg_rdata_o = '0;
      endcase
    end
  end

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
    assign core_key_o[g*WORD_W +: WORD_W] = key_q[g];
  end

  assign core_key_size_o = ctrl_q[4:3];
  assign core_encrypt_o  = ctrl_q[C_DIR] || mode == CM_CTR;
  assign irq_o           = |(stat_q & ien_q);
  assign dma_in_req_o    = dma_q[0] && dma_q[1] && seq_state == SQ_FILL;
  assign dma_out_req_o   = dma_q[0] && dma_q[2] && seq_state == SQ_DRAIN;

  assert_out_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_evt |=> stat_q[I_OUT]);
  assert_iv_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !out_evt) |=> $stable(iv_q));
  assert_dma_phase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dma_in_req_o && dma_out_req_o));
endmodule

// File: tb/tb_cipher_regfront.sv
module tb_cipher_regfront;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         irq, dma_in, dma_out, core_start, core_enc;
  logic [127:0] core_din;
  logic [255:0] core_key;
  logic [1:0]   core_ksz;
  logic         core_done = 1'b0;
  logic [127:0] core_dout = '0;
  int           n_chk = 0, n_fail = 0, cyc = 0, lat = 0;

  always #10 clk = ~clk;

  cipher_regfront dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .dma_in_req_o(dma_in), .dma_out_req_o(dma_out),
    .core_start_o(core_start), .core_din_o(core_din), .core_key_o(core_key),
    .core_key_size_o(core_ksz), .core_encrypt_o(core_enc),
    .core_done_i(core_done), .core_dout_i(core_dout));

  function automatic logic [127:0] fcore(logic [127:0] d, logic [255:0] k, bit enc);
    if (enc) return {d[95:0], d[127:96]} ^ k[127:0];
    return d ^ k[127:0] ^ {4{32'h5a5a5a5a}};
  endfunction

  // stand-in cipher core, three cycles of latency
  always @(posedge clk) begin
    core_done <= 1'b0;
    if (core_start) begin
      core_dout <= fcore(core_din, core_key, core_enc);
      lat <= 3;
    end else if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) core_done <= 1'b1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_bit(input int b, output bit seen);
    logic [31:0] s;
    seen = 1'b0;
    for (int i = 0; i < 50 && !seen; i++) begin
      rd(8'h8C, s);
      seen = s[b];
    end
  endtask

  task automatic clr_bit(input int b);
    logic [31:0] s;
    rd(8'h8C, s);
    wr(8'h8C, s & ~(32'd1 << b));
  endtask

  task automatic start_op(input logic [255:0] key, input logic [1:0] ksz, input int mode,
                          input bit enc, input logic [127:0] iv, input logic [31:0] len);
    logic [31:0] c;
    for (int i = 0; i < 8; i++) wr(8'(i*4), key[i*32 +: 32]);
    for (int i = 0; i < 4; i++) wr(8'h40 + 8'(i*4), iv[i*32 +: 32]);
    c = {24'b0, (mode == 3), (mode == 2), (mode == 1), ksz, enc, 2'b00};
    wr(8'h50, c);
    wr(8'h54, len);
  endtask

  task automatic push_block(input logic [127:0] b);
    for (int i = 0; i < 4; i++) wr(8'h60 + 8'(i*4), b[i*32 +: 32]);
  endtask

  task automatic pull_block(output logic [127:0] o);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      rd(8'h60 + 8'(i*4), w);
      o[i*32 +: 32] = w;
    end
  endtask

  task automatic model_step(input int mode, input bit enc, input logic [255:0] key,
                            inout logic [127:0] iv, input logic [127:0] b, output logic [127:0] o);
    if (mode == 0) o = fcore(b, key, enc);
    else if (mode == 1) begin
      if (enc) begin o = fcore(b ^ iv, key, 1'b1); iv = o; end
      else begin o = fcore(b, key, 1'b0) ^ iv; iv = b; end
    end else begin
      o = b ^ fcore(iv, key, 1'b1);
      iv = iv + 128'd1;
    end
  endtask

  task automatic check_iv(input logic [127:0] exp);
    logic [127:0] got;
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin rd(8'h40 + 8'(i*4), w); got[i*32 +: 32] = w; end
    chk(got == exp, "R8 vector readback", got, exp);
  endtask

  task automatic run_op(input int mode, input bit enc, input logic [255:0] key,
                        input logic [1:0] ksz, input logic [127:0] iv, input int len);
    logic [127:0] ivm, b, o, e;
    logic [31:0] w;
    bit seen;
    int rem;
    ivm = iv; rem = len;
    start_op(key, ksz, mode, enc, iv, 32'(len));
    while (rem > 0) begin
      wait_bit(1, seen);
      chk(seen, "R2 input wanted", 128'(seen), 128'd1);
      clr_bit(1);
      b = {$urandom, $urandom, $urandom, $urandom};
      push_block(b);
      model_step(mode, enc, key, ivm, b, e);
      wait_bit(2, seen);
      chk(seen, "R5 output available", 128'(seen), 128'd1);
      clr_bit(2);
      pull_block(o);
      chk(o == e, "R4 block result", o, e);
      rem = rem - ((rem < 16) ? rem : 16);
      rd(8'h54, w);
      chk(w == 32'(rem), "R6 remaining count", 128'(w), 128'(rem));
    end
    rd(8'h8C, w);
    chk(w[1] == 1'b0, "R6 idle after last block", 128'(w), 128'd0);
    check_iv(ivm);
  endtask

  initial begin
    logic [31:0] w;
    logic [127:0] o, e, ivm, b;
    logic [255:0] key;
    bit seen;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h50, w); chk(w == 0, "R1 control reset", 128'(w), 128'd0);
    rd(8'h54, w); chk(w == 0, "R1 length reset", 128'(w), 128'd0);
    rd(8'h8C, w); chk(w == 0, "R1 status reset", 128'(w), 128'd0);
    rd(8'h40, w); chk(w == 0, "R1 vector reset", 128'(w), 128'd0);
    chk({irq, dma_in, dma_out} == 3'b0, "R1 outputs low", 128'({irq, dma_in, dma_out}), 128'd0);
    rd(8'h80, w); chk(w == 32'h0000_0205, "R1 revision", 128'(w), 128'h205);

    // R12 store-only lengths
    wr(8'h58, 32'h0); wr(8'h5C, 32'h0000_0031);
    rd(8'h58, w); chk(w == 0, "R12 second length", 128'(w), 128'd0);
    rd(8'h5C, w); chk(w == 32'h31, "R12 assoc length", 128'(w), 128'h31);

    // R10 key wiring and size field
    key = {8{$urandom}};
    for (int i = 0; i < 8; i++) key[i*32 +: 32] = $urandom;
    for (int i = 0; i < 8; i++) wr(8'(i*4), key[i*32 +: 32]);
    wr(8'h50, 32'h10);
    @(negedge clk);
    chk(core_ksz == 2'd2, "R10 key size code", 128'(core_ksz), 128'd2);
    chk(core_key == key, "R10 key bus", core_key[127:0], key[127:0]);
    rd(8'h04, w); chk(w == 0, "R10 key reads zero", 128'(w), 128'd0);
    wr(8'h20, 32'hdead_beef);
    @(negedge clk);
    chk(core_key == key, "R10 upper key window dropped", core_key[255:128], key[255:128]);

    // R2 irq enable and mask, R11 writes ignored mid-operation
    wr(8'h90, 32'h6);
    ivm = 128'h0123_4567_89ab_cdef_0011_2233_4455_6677;
    start_op(key, 2'd1, 0, 1'b1, ivm, 32'd16);
    @(negedge clk);
    chk(irq == 1'b1, "R2 irq on input wanted", 128'(irq), 128'd1);
    wr(8'h90, 32'h4);
    @(negedge clk);
    chk(irq == 1'b0, "R2 masked input flag", 128'(irq), 128'd0);
    wr(8'h90, 32'h0);
    clr_bit(1);
    wr(8'h40, 32'hffff_ffff);
    wr(8'h50, 32'h44);
    wr(8'h54, 32'd99);
    wr(8'h00, 32'h1);
    rd(8'h54, w); chk(w == 16, "R11 length locked", 128'(w), 128'd16);
    b = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < 3; i++) wr(8'h60 + 8'(i*4), b[i*32 +: 32]);
    rd(8'h60, w);
    repeat (8) @(negedge clk);
    rd(8'h8C, w); chk(w[2] == 1'b0, "R3 no start on three words", 128'(w), 128'd0);
    rd(8'h54, w); chk(w == 16, "R11 window read ignored", 128'(w), 128'd16);
    wr(8'h6C, b[127:96]);
    wait_bit(2, seen);
    chk(seen, "R5 output after fourth word", 128'(seen), 128'd1);
    pull_block(o);
    e = fcore(b, key, 1'b1);
    chk(o == e, "R11 control kept during op", o, e);
    check_iv(ivm);
    clr_bit(2);

    // R9 DMA requests, R7 status write semantics
    wr(8'h84, 32'h61);
    start_op(key, 2'd3, 1, 1'b0, ivm, 32'd16);
    @(negedge clk);
    chk({dma_in, dma_out} == 2'b10, "R9 input request", 128'({dma_in, dma_out}), 128'b10);
    b = {$urandom, $urandom, $urandom, $urandom};
    push_block(b);
    wait_bit(2, seen);
    chk({dma_in, dma_out} == 2'b01, "R9 output request", 128'({dma_in, dma_out}), 128'b01);
    wr(8'h84, 32'h60);
    @(negedge clk);
    chk(dma_out == 1'b0, "R9 start bit gates", 128'(dma_out), 128'd0);
    wr(8'h84, 32'h0);
    wr(8'h8C, 32'hffff_ffff);
    rd(8'h8C, w); chk(w[2] == 1'b1, "R7 write one keeps", 128'(w), 128'h4);
    wr(8'h8C, 32'hffff_fffb);
    rd(8'h8C, w); chk(w[2] == 1'b0, "R7 write zero clears", 128'(w), 128'd0);
    wr(8'h8C, 32'h0);
    pull_block(o);
    e = fcore(b, key, 1'b0) ^ ivm;
    chk(o == e, "R4 chained decrypt", o, e);
    check_iv(b);

    // R8 counter wrap, short final block
    run_op(2, 1'b0, key, 2'd1, {128{1'b1}}, 20);
    run_op(3, 1'b1, key, 2'd3, {128{1'b1}}, 5);

    for (int n = 0; n < 25; n++) begin
      for (int i = 0; i < 8; i++) key[i*32 +: 32] = $urandom;
      run_op(int'($urandom % 4), 1'($urandom), key, 2'(1 + $urandom % 3),
             {$urandom, $urandom, $urandom, $urandom}, 1 + int'($urandom % 72));
    end

    summary();
    $finish;
  end
endmodule